// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the run, idle and power-down states of a small 8-bit microcontroller core. It halves the raw input clock with a toggle flop. It then hands out two clock enables, one for the CPU and one for the peripheral set, each gated by the current mode. It also drives the oscillator-run enable, a reset request for the special function registers and a write-inhibit for internal RAM.

Software starts a mode with a one-cycle request strobe. Idle freezes the CPU while the peripherals keep ticking, and a pending enabled interrupt or the reset pin ends it. A reset that ends idle does not stop the CPU at once. The CPU runs for two more machine cycles, with RAM writes blocked and port writes left alone, and only then does the register reset begin. Power-down stops the oscillator, and only the reset pin can end it. After the oscillator restarts, the register reset is held for a programmable number of input clocks before any clock enable is released. No reset path ever clears RAM; the write-inhibit stays high whenever a reset is in progress.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While running, `cpu_clk_en` and `per_clk_en` each pulse on every second input clock, and neither is high on two consecutive input clocks.
- R2: A `req_idle` strobe in run mode stops `cpu_clk_en` from the next cycle, while `per_clk_en` keeps pulsing every second clock.
- R3: A high `irq_pend` in idle returns to run. The CPU enable resumes, and neither `sfr_rst` nor `ram_wr_inh` is raised.
- R4: When `rst_pin` is seen in idle, the CPU enable gives exactly WIN_MC*MC_TICKS further pulses (12 by default: 2 machine cycles of 6 divided clocks each). `ram_wr_inh` is high and `sfr_rst` is low throughout that window. After the window, `sfr_rst` is asserted.
- R5: A `req_pdown` strobe drives `osc_en` low from the next cycle. In power-down both clock enables are low and `ram_wr_inh` is high.
- R6: `irq_pend` has no effect in power-down. `osc_en` stays low and no clock enable pulses.
- R7: `rst_pin` in power-down raises `osc_en` on the next cycle. `sfr_rst` then stays high for at least HOLD_CYC input clocks, even if the pin is released sooner, and it drops one cycle after both the count is done and the pin is low. No clock enable pulses before `sfr_rst` drops.
- R8: If `req_idle` and `req_pdown` are strobed in the same cycle, the block enters power-down.
- R9: `rst_pin` in run mode raises `sfr_rst` and `ram_wr_inh` and stops both enables from the next cycle. Run resumes one cycle after the pin is seen low.
- R10: After `por_n` is released the block is in run: `osc_en` high, `sfr_rst` and `ram_wr_inh` low.
- R11: In run mode `rst_pin` has priority over a request strobe in the same cycle. The strobe is dropped, and the block returns to run, not idle, after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| rst_pin | input | 1 | External hardware reset pin, synchronous, active high |
| req_idle | input | 1 | Software idle request strobe |
| req_pdown | input | 1 | Software power-down request strobe |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock enable at the divided rate |
| per_clk_en | output | 1 | Peripheral clock enable at the divided rate |
| osc_en | output | 1 | Oscillator run enable |
| sfr_rst | output | 1 | Special function register reset request |
| ram_wr_inh | output | 1 | Internal RAM write inhibit |

## Verification
A mode register stuck in the wrong state shows up within two input clocks as a missing or extra pulse on one of the two clock enables, because each enable pulses every other cycle while it is allowed. A wrong window or hold counter shows up as a CPU pulse count other than twelve after an idle reset, or as an `sfr_rst` high time other than HOLD_CYC+1 cycles after a power-down wake. The bench therefore counts pulses and high cycles over fixed windows in every mode, and it uses a small hold count so that each wake path runs to completion.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_IDLE_RST = 3'd2,
        ST_RESET    = 3'd3,
        ST_PDOWN    = 3'd4,
        ST_PD_WAKE  = 3'd5
    } pmc_state_e;

endpackage

// File: rtl/pmc_clkdiv.sv
module pmc_clkdiv (
    input  logic clk,
    input  logic por_n,
    input  logic run_osc,
    output logic tick
);
    logic div_d, div_q;

    // toggle flop; frozen low while the oscillator is stopped
    always_comb begin
        div_d = run_osc ? ~div_q : 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) div_q <= 1'b0;
        else        div_q <= div_d;
    end

    assign tick = div_q;

    assert_div_alternate_R1: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !tick);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int MC_TICKS = 6,
    parameter int WIN_MC   = 2,
    parameter int HOLD_CYC = 1024
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick,
    input  logic       rst_pin,
    input  logic       req_idle,
    input  logic       req_pdown,
    input  logic       irq_pend,
    output pmc_state_e state
);
    localparam int WIN_TICKS = MC_TICKS * WIN_MC;
    localparam int CNT_MAX   = (HOLD_CYC > WIN_TICKS) ? HOLD_CYC : WIN_TICKS;
    localparam int CW        = $clog2(CNT_MAX + 1);

    typedef struct packed {
        pmc_state_e    st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_RUN: begin
                if (rst_pin) begin
                    d.st  = ST_RESET;
                    d.cnt = '0;
                end else if (req_pdown) begin
                    d.st = ST_PDOWN;
                end else if (req_idle) begin
                    d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (rst_pin) begin
                    d.st  = ST_IDLE_RST;
                    d.cnt = '0;
                end else if (irq_pend) begin
                    d.st = ST_RUN;
                end
            end
            ST_IDLE_RST: begin
                if (tick) begin
                    if (q.cnt == CW'(WIN_TICKS - 1)) begin
                        d.st  = ST_RESET;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_RESET: begin
                if (!rst_pin) d.st = ST_RUN;
            end
            ST_PDOWN: begin
                if (rst_pin) begin
                    d.st  = ST_PD_WAKE;
                    d.cnt = '0;
                end
            end
            ST_PD_WAKE: begin
                if (q.cnt == CW'(HOLD_CYC - 1)) begin
                    d.st  = ST_RESET;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.st  = ST_RESET;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.st  <= ST_RUN;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign state = q.st;

    assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_RUN && !rst_pin && !req_pdown && req_idle) |=> (q.st == ST_IDLE));

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_IDLE_RST) |-> (q.cnt < CW'(WIN_TICKS)));

    assert_pdown_no_irq_wake_R6: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_PDOWN && !rst_pin) |=> (q.st == ST_PDOWN));

    assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_PD_WAKE && q.cnt < CW'(HOLD_CYC - 1)) |=> (q.st == ST_PD_WAKE));

    assert_pdown_priority_R8: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == ST_RUN && !rst_pin && req_pdown) |=> (q.st == ST_PDOWN));

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
    import pmc_pkg::*;
(
    input  pmc_state_e state,
    input  logic       tick,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       sfr_rst,
    output logic       ram_wr_inh
);
    logic cpu_run, per_run;

    always_comb begin
        cpu_run    = 1'b0;
        per_run    = 1'b0;
        osc_en     = 1'b1;
        sfr_rst    = 1'b0;
        ram_wr_inh = 1'b0;
        case (state)
            ST_RUN: begin
                cpu_run = 1'b1;
                per_run = 1'b1;
            end
            ST_IDLE: begin
                per_run = 1'b1;
            end
            ST_IDLE_RST: begin
                cpu_run    = 1'b1;
                per_run    = 1'b1;
                ram_wr_inh = 1'b1;
            end
            ST_RESET, ST_PD_WAKE: begin
                sfr_rst    = 1'b1;
                ram_wr_inh = 1'b1;
            end
            ST_PDOWN: begin
                osc_en     = 1'b0;
                ram_wr_inh = 1'b1;
            end
            default: begin
                sfr_rst    = 1'b1;
                ram_wr_inh = 1'b1;
            end
        endcase
    end

    assign cpu_clk_en = cpu_run & tick;
    assign per_clk_en = per_run & tick;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int MC_TICKS = 6,
    parameter int WIN_MC   = 2,
    parameter int HOLD_CYC = 1024
) (
    input  logic clk_in,
    input  logic por_n,
    input  logic rst_pin,
    input  logic req_idle,
    input  logic req_pdown,
    input  logic irq_pend,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic sfr_rst,
    output logic ram_wr_inh
);
    pmc_state_e state;
    logic       tick;

    pmc_clkdiv u_div (
        .clk     (clk_in),
        .por_n   (por_n),
        .run_osc (osc_en),
        .tick    (tick)
    );

    pmc_fsm #(
        .MC_TICKS (MC_TICKS),
        .WIN_MC   (WIN_MC),
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk       (clk_in),
        .por_n     (por_n),
        .tick      (tick),
        .rst_pin   (rst_pin),
        .req_idle  (req_idle),
        .req_pdown (req_pdown),
        .irq_pend  (irq_pend),
        .state     (state)
    );

    pmc_gate u_gate (
        .state      (state),
        .tick       (tick),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en),
        .sfr_rst    (sfr_rst),
        .ram_wr_inh (ram_wr_inh)
    );

    assert_pdown_silent_R5: assert property (@(posedge clk_in) disable iff (!por_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en && ram_wr_inh));

    assert_reset_guards_ram_R9: assert property (@(posedge clk_in) disable iff (!por_n)
        sfr_rst |-> (ram_wr_inh && !cpu_clk_en && !per_clk_en));

    assert_pdown_exit_osc_R7: assert property (@(posedge clk_in) disable iff (!por_n)
        (!osc_en && rst_pin) |=> osc_en);

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int HOLD = 16;
    localparam int WIN  = 12;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin = 1'b0, req_idle = 1'b0, req_pdown = 1'b0, irq_pend = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inh;

    int checks = 0, failures = 0;
    int n_cpu, n_per, n_sfr, n_inh, n_osc_lo, n_b2b, n_cpu_noinh;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.MC_TICKS(6), .WIN_MC(2), .HOLD_CYC(HOLD)) dut (
        .clk_in(clk), .por_n(por_n), .rst_pin(rst_pin), .req_idle(req_idle),
        .req_pdown(req_pdown), .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .sfr_rst(sfr_rst),
        .ram_wr_inh(ram_wr_inh)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic run_cycles(input int n);
        logic pc, pp;
        n_cpu = 0; n_per = 0; n_sfr = 0; n_inh = 0; n_osc_lo = 0; n_b2b = 0; n_cpu_noinh = 0;
        pc = 1'b0; pp = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            n_cpu    += int'(cpu_clk_en);
            n_per    += int'(per_clk_en);
            n_sfr    += int'(sfr_rst);
            n_inh    += int'(ram_wr_inh);
            n_osc_lo += int'(!osc_en);
            n_cpu_noinh += int'(cpu_clk_en && !ram_wr_inh);
            if ((pc && cpu_clk_en) || (pp && per_clk_en)) n_b2b++;
            pc = cpu_clk_en; pp = per_clk_en;
        end
    endtask

    task automatic pulse_req(input bit idl, input bit pd);
        req_idle = idl; req_pdown = pd;
        @(negedge clk);
        req_idle = 1'b0; req_pdown = 1'b0;
    endtask

    // R7: wake from power-down with the pin held for only three cycles
    task automatic pd_wake(input string tag);
        rst_pin = 1'b1;
        run_cycles(3);
        chk({tag, " R7 osc restarts"}, n_osc_lo, 0);
        chk({tag, " R7 sfr during pin"}, n_sfr, 3);
        rst_pin = 1'b0;
        run_cycles(HOLD - 2);
        chk({tag, " R7 sfr held after pin release"}, n_sfr, HOLD - 2);
        chk({tag, " R7 no cpu during hold"}, n_cpu, 0);
        chk({tag, " R7 no per during hold"}, n_per, 0);
        run_cycles(20);
        chk({tag, " R7 sfr dropped"}, n_sfr, 0);
        chk({tag, " R7 cpu resumes"}, n_cpu, 10);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        run_cycles(1);
        // R10 reset state
        chk("R10 osc_en", int'(osc_en), 1);
        chk("R10 sfr_rst", int'(sfr_rst), 0);
        chk("R10 ram_wr_inh", int'(ram_wr_inh), 0);

        // R1 divided enables in run
        run_cycles(40);
        chk("R1 cpu pulses", n_cpu, 20);
        chk("R1 per pulses", n_per, 20);
        chk("R1 back-to-back", n_b2b, 0);

        // R2 idle entry
        pulse_req(1'b1, 1'b0);
        run_cycles(40);
        chk("R2 cpu stopped", n_cpu, 0);
        chk("R2 per running", n_per, 20);
        chk("R2 osc stays on", n_osc_lo, 0);

        // R3 interrupt ends idle
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        run_cycles(40);
        chk("R3 cpu resumes", n_cpu, 20);
        chk("R3 no sfr_rst", n_sfr, 0);
        chk("R3 no inhibit", n_inh, 0);

        // R4 reset ends idle
        pulse_req(1'b1, 1'b0);
        run_cycles(4);
        rst_pin = 1'b1;
        run_cycles(60);
        chk("R4 cpu window pulses", n_cpu, WIN);
        chk("R4 per window pulses", n_per, WIN);
        chk("R4 cpu pulse without inhibit", n_cpu_noinh, 0);
        chk_rng("R4 sfr after window", n_sfr, 60 - 2 * WIN, 61 - 2 * WIN);
        chk("R4 inhibit window+reset", n_inh, 60);
        rst_pin = 1'b0;
        run_cycles(20);
        chk("R4 run after reset", n_cpu, 10);
        chk("R4 sfr released", n_sfr, 0);

        // R5 / R6 power-down with interrupt pending
        pulse_req(1'b0, 1'b1);
        irq_pend = 1'b1;
        run_cycles(30);
        chk("R5 osc off", n_osc_lo, 30);
        chk("R5 inhibit", n_inh, 30);
        chk("R6 cpu silent with irq", n_cpu, 0);
        chk("R6 per silent with irq", n_per, 0);
        irq_pend = 1'b0;
        pd_wake("pd1");

        // R8 both requests together
        pulse_req(1'b1, 1'b1);
        run_cycles(10);
        chk("R8 pdown wins osc", n_osc_lo, 10);
        chk("R8 pdown wins per", n_per, 0);
        pd_wake("pd2");

        // R9 / R11 reset in run with simultaneous idle request
        rst_pin = 1'b1; req_idle = 1'b1;
        @(negedge clk);
        req_idle = 1'b0;
        chk("R9 sfr next cycle", int'(sfr_rst), 1);
        run_cycles(5);
        chk("R9 sfr held", n_sfr, 5);
        chk("R9 inhibit held", n_inh, 5);
        chk("R9 cpu stopped", n_cpu, 0);
        rst_pin = 1'b0;
        run_cycles(20);
        chk("R9 run resumes", n_sfr, 0);
        chk("R11 request dropped cpu", n_cpu, 10);
        chk("R11 request dropped per", n_per, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule